// File: doc/BRIEF.md
# Translation Fault Recorder

This block sits beside an address translation unit and keeps a record of the faults that unit raises. A fault arrives as a one-cycle strobe with a 3-bit type code and the address that failed to translate. The recorder sets one status bit per fault type and saves the faulting address in one of four capture registers. Several fault types share a capture register. It raises an interrupt while any status bit is set. It also holds the translation unit blocked until software has cleared every pending fault and then written the control register with its enable bit set.

Software reaches the block through a simple 32-bit register port: a write strobe, an 8-bit byte offset, write data and combinational read data. Faults are cleared by writing ones to the bit positions to be cleared. A read-only register names the lowest-numbered pending fault, which is the one software services first.

Top module: `fault_recorder`

## Requirements
- R1: A fault strobe with type code t (0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access) sets bit t of the status register at offset 0x018, readable from the cycle after the strobe.
- R2: Writing the clear register at 0x01C clears every status bit written as 1 and leaves the bits written as 0 unchanged. Writing the status register at 0x018 has no effect.
- R3: `irqOut` is high exactly while any status bit is set. It falls in the cycle after the write that clears the last set bit.
- R4: The faulting address is captured as follows: type 0 to offset 0x024; types 2, 6 and 7 to 0x028; types 1, 4 and 5 to 0x02C; type 3 to 0x030.
- R5: A capture register loads only when the strobed type's status bit is clear. A repeated fault of a type still pending leaves the first address in place, and a fault of that type after its bit is cleared loads the new address.
- R6: When a fault strobe and a clear of the same bit occur in the same cycle, the bit stays set and no new address is captured.
- R7: `holdOut` rises in the cycle after any fault strobe and stays high while any status bit is set.
- R8: `holdOut` falls only after a write to the control register at 0x000 with bit 0 set, made when no status bit is set or left set by that cycle. Clearing the faults alone, or a control write while faults are pending, leaves it high. Reading 0x000 returns `holdOut` in bit 0.
- R9: Offset 0x020 reads bit 8 as 1 when any fault is pending and bits 2:0 as the index of the lowest-numbered set status bit. It reads zero when nothing is pending.
- R10: After reset, all status bits, capture registers, `irqOut` and `holdOut` are zero.
- R11: Reads of an offset not listed above return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultValid | input | 1 | One-cycle fault strobe from the translation unit |
| faultType | input | 3 | Fault type code, valid with the strobe |
| faultAddr | input | ADDR_W | Faulting address, valid with the strobe |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt, high while any fault is pending |
| holdOut | output | 1 | Keeps the translation unit blocked |

## Verification
Every state change lands on the single clock edge that samples the strobe or the write. The status bits, capture registers, pending index and `holdOut` are therefore due one cycle after the stimulus. `irqOut` and read data follow that state with no further register. The bench drives inputs on the falling edge and holds them for one full cycle. It samples on the next falling edge, which comes after the one edge that acts on them. For the drop of `irqOut` and the retention of `holdOut`, it samples the cycle right after the clearing write.

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;
  localparam int NUM_TYPES = 8;
  localparam int TYPE_W    = 3;
  localparam int REG_AW    = 8;
  localparam int DATA_W    = 32;
  localparam int NUM_GRP   = 4;

  localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STATUS = 8'h18;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_PEND   = 8'h20;
  localparam logic [REG_AW-1:0] OFS_PAGE   = 8'h24;
  localparam logic [REG_AW-1:0] OFS_WRSIDE = 8'h28;
  localparam logic [REG_AW-1:0] OFS_RDSIDE = 8'h2C;
  localparam logic [REG_AW-1:0] OFS_BUS    = 8'h30;

  typedef enum logic [1:0] {
    GRP_PAGE   = 2'd0,
    GRP_WRSIDE = 2'd1,
    GRP_RDSIDE = 2'd2,
    GRP_BUS    = 2'd3
  } capGrp_e;

  typedef struct packed {
    logic [NUM_TYPES-1:0] setMask;
    logic [NUM_TYPES-1:0] clrMask;
    logic [NUM_GRP-1:0]   capEn;
    logic                 relReq;
  } ctlStrobe_t;

  function automatic capGrp_e grpOf(input logic [TYPE_W-1:0] t);
    case (t)
      3'd0:                grpOf = GRP_PAGE;
      3'd3:                grpOf = GRP_BUS;
      3'd1, 3'd4, 3'd5:    grpOf = GRP_RDSIDE;
      default:             grpOf = GRP_WRSIDE;
    endcase
  endfunction
endpackage

// File: rtl/fault_rec_ctrl.sv
module fault_rec_ctrl
  import fault_rec_pkg::*;
(
  input  logic                 faultValid,
  input  logic [TYPE_W-1:0]    faultType,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWdata,
  input  logic [NUM_TYPES-1:0] statusQ,
  output ctlStrobe_t           strb
);
  logic unusedWdata;
  assign unusedWdata = ^regWdata[DATA_W-1:NUM_TYPES];

  always_comb begin
    strb = '0;
    if (faultValid) begin
      strb.setMask[faultType] = 1'b1;
      if (!statusQ[faultType]) strb.capEn[grpOf(faultType)] = 1'b1;
    end
    if (regWrEn && regAddr == OFS_CLEAR) strb.clrMask = regWdata[NUM_TYPES-1:0];
    if (regWrEn && regAddr == OFS_CTRL && regWdata[0]) strb.relReq = 1'b1;
  end
endmodule

// File: rtl/fault_rec_dp.sv
module fault_rec_dp
  import fault_rec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [ADDR_W-1:0]    faultAddr,
  input  logic [REG_AW-1:0]    regAddr,
  output logic [DATA_W-1:0]    regRdata,
  output logic [NUM_TYPES-1:0] statusQ,
  output logic                 holdQ
);
  localparam int IDX_W = $clog2(NUM_TYPES);

  logic [NUM_TYPES-1:0] statusNext;
  logic [ADDR_W-1:0]    capQ [NUM_GRP];
  logic [IDX_W-1:0]     lowIdx;

  assign statusNext = (statusQ & ~strb.clrMask) | strb.setMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            holdQ <= 1'b0;
    else if (|strb.setMask)               holdQ <= 1'b1;
    else if (strb.relReq && ~|statusNext) holdQ <= 1'b0;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gCap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              capQ[g] <= '0;
      else if (strb.capEn[g]) capQ[g] <= faultAddr;
    end
  end

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_TYPES - 1; i >= 0; i--)
      if (statusQ[i]) lowIdx = IDX_W'(i);
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL:   regRdata = DATA_W'(holdQ);
      OFS_STATUS: regRdata = DATA_W'(statusQ);
      OFS_PEND:   regRdata = (|statusQ) ? (DATA_W'(lowIdx) | DATA_W'(9'h100)) : '0;
      OFS_PAGE:   regRdata = DATA_W'(capQ[GRP_PAGE]);
      OFS_WRSIDE: regRdata = DATA_W'(capQ[GRP_WRSIDE]);
      OFS_RDSIDE: regRdata = DATA_W'(capQ[GRP_RDSIDE]);
      OFS_BUS:    regRdata = DATA_W'(capQ[GRP_BUS]);
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/fault_recorder.sv
module fault_recorder
  import fault_rec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultValid,
  input  logic [2:0]        faultType,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irqOut,
  output logic              holdOut
);
  ctlStrobe_t           strb;
  logic [NUM_TYPES-1:0] statusQ;

  fault_rec_ctrl u_ctrl (
    .faultValid(faultValid),
    .faultType (faultType),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .statusQ   (statusQ),
    .strb      (strb)
  );

  fault_rec_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .faultAddr(faultAddr),
    .regAddr  (regAddr),
    .regRdata (regRdata),
    .statusQ  (statusQ),
    .holdQ    (holdOut)
  );

  assign irqOut = |statusQ;
endmodule

// File: rtl/fault_recorder_chk.sv
module fault_recorder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        faultValid,
  input logic        regWrEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic        irqOut,
  input logic        holdOut
);
  AST_FAULT_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> irqOut); // R3

  AST_FAULT_SETS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |=> holdOut); // R7

  AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> holdOut); // R7

  AST_FULL_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h1C && regWdata[7:0] == 8'hFF && !faultValid) |=> !irqOut); // R3

  AST_HOLD_RELEASE_NEEDS_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdOut) |-> $past(regWrEn && regAddr == 8'h00 && regWdata[0])); // R8
endmodule

bind fault_recorder fault_recorder_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .faultValid(faultValid),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .irqOut    (irqOut),
  .holdOut   (holdOut)
);

// File: tb/sim_fault_recorder.sv
`timescale 1ns/1ps
module sim_fault_recorder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        faultValid = 1'b0;
  logic [2:0]  faultType = '0;
  logic [31:0] faultAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;
  logic        holdOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fault_recorder u0 (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultType(faultType),
    .faultAddr(faultAddr), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut), .holdOut(holdOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0; regWdata = '0;
  endtask

  task automatic fault(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk);
    faultValid = 1'b1; faultType = t; faultAddr = a;
    @(negedge clk);
    faultValid = 1'b0;
  endtask

  function automatic logic [7:0] capOfs(input int t);
    case (t)
      0:       capOfs = 8'h24;
      3:       capOfs = 8'h30;
      1, 4, 5: capOfs = 8'h2C;
      default: capOfs = 8'h28;
    endcase
  endfunction

  task automatic testReset();
    logic [31:0] d;
    check("R10 irq", 32'(irqOut), 0);
    check("R10 hold", 32'(holdOut), 0);
    rd(8'h18, d); check("R10 status", d, 0);
    rd(8'h24, d); check("R10 page addr", d, 0);
    rd(8'h30, d); check("R10 bus addr", d, 0);
  endtask

  task automatic testEachType();
    logic [31:0] d;
    for (int t = 0; t < 8; t++) begin
      logic [31:0] a = 32'h1000_0000 + 32'(t) * 32'h111;
      fault(3'(t), a);
      rd(8'h18, d); check("R1 status bit", d, 32'(1) << t);
      check("R3 irq set", 32'(irqOut), 1);
      check("R7 hold set", 32'(holdOut), 1);
      rd(capOfs(t), d); check("R4 capture map", d, a);
      rd(8'h20, d); check("R9 pending idx", d, 32'h100 | 32'(t));
      wr(8'h1C, 32'(1) << t);
      check("R3 irq drop", 32'(irqOut), 0);
      check("R8 hold kept after clear", 32'(holdOut), 1);
      rd(8'h20, d); check("R9 none pending", d, 0);
      wr(8'h00, 32'h5);
      check("R8 hold released", 32'(holdOut), 0);
    end
  endtask

  task automatic testSticky();
    logic [31:0] d;
    fault(3'd0, 32'hAAAA_0000);
    fault(3'd0, 32'hBBBB_0000);
    rd(8'h24, d); check("R5 first addr kept", d, 32'hAAAA_0000);
    wr(8'h1C, 32'h01);
    fault(3'd0, 32'hCCCC_0000);
    rd(8'h24, d); check("R5 reload after clear", d, 32'hCCCC_0000);
    wr(8'h1C, 32'h01);
    wr(8'h00, 32'h1);
  endtask

  task automatic testMulti();
    logic [31:0] d;
    fault(3'd5, 32'h5);
    fault(3'd2, 32'h2);
    fault(3'd6, 32'h6);
    rd(8'h18, d); check("R1 multi status", d, 32'h64);
    rd(8'h20, d); check("R9 lowest first", d, 32'h102);
    wr(8'h1C, 32'h00);
    rd(8'h18, d); check("R2 zero write no effect", d, 32'h64);
    wr(8'h18, 32'hFF);
    rd(8'h18, d); check("R2 status write ignored", d, 32'h64);
    wr(8'h1C, 32'h04);
    rd(8'h20, d); check("R9 next lowest", d, 32'h105);
    rd(8'h18, d); check("R2 selective clear", d, 32'h60);
    wr(8'h00, 32'h5);
    check("R8 ctrl while pending", 32'(holdOut), 1);
    rd(8'h00, d); check("R8 ctrl readback", d, 1);
    wr(8'h1C, 32'h60);
    check("R3 irq after last", 32'(irqOut), 0);
    wr(8'h00, 32'h4);
    check("R8 bit0 clear no release", 32'(holdOut), 1);
    wr(8'h00, 32'h1);
    check("R8 release", 32'(holdOut), 0);
  endtask

  task automatic testSameCycle();
    logic [31:0] d;
    fault(3'd3, 32'h3333_0000);
    @(negedge clk);
    faultValid = 1'b1; faultType = 3'd3; faultAddr = 32'h4444_0000;
    regWrEn = 1'b1; regAddr = 8'h1C; regWdata = 32'h08;
    @(negedge clk);
    faultValid = 1'b0; regWrEn = 1'b0; regWdata = '0;
    rd(8'h18, d); check("R6 bit stays set", d, 32'h08);
    rd(8'h30, d); check("R6 no new capture", d, 32'h3333_0000);
    check("R6 irq stays", 32'(irqOut), 1);
    wr(8'h1C, 32'hFF);
    wr(8'h00, 32'h1);
    check("R8 release after R6", 32'(holdOut), 0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    fault(3'd7, 32'h7777_0000);
    rd(8'h04, d); check("R11 unmapped 0x04", d, 0);
    rd(8'h3C, d); check("R11 unmapped 0x3C", d, 0);
    wr(8'h1C, 32'h80);
    wr(8'h00, 32'h1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEachType();
    testSticky();
    testMulti();
    testSameCycle();
    testUnmapped();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule